// File: doc/BRIEF.md
# Dual-Issue Warp Scheduler

This block is one warp scheduler of a GPU-style streaming multiprocessor. It owns a fixed table of resident warp slots. A warp is placed into a free slot through the admit port and stays in that slot, bound to this scheduler, until the retire port clears it. Several copies of the block can sit side by side in one multiprocessor. Each copy keeps its own slot table, and the copies never talk to one another.

In every cycle the scheduler looks for an eligible warp. A warp is eligible when it is resident, its operands are ready, and the unit class of its next instruction is free. The search is loose round-robin: it starts at the slot after the warp issued last. For the chosen warp the first instruction always issues. The second one issues in the same cycle only if it does not depend on the first, targets a different unit class, and that class is free. Changing to a different warp costs nothing, so a new warp can issue on every cycle. The issue result is registered.

Top module: `dual_issue_warp_sched`

## Requirements
- R1: While reset is low and after it is released, every issue output is 0 and no slot is resident, so no issue takes place until a warp is admitted.
- R2: An admit pulse to a free slot makes that slot resident with the given warp ID from the next cycle. An admit to a slot that is already resident is ignored, and the warp ID stored there is kept.
- R3: A retire pulse clears the slot's resident bit from the next cycle, and a cleared slot is never issued. When retire and admit name the same slot in one cycle, the retire wins.
- R4: A slot is eligible only when it is resident, its ready bit is 1, and unit_busy[c] is 0 for the class c of its first instruction.
- R5: Among eligible slots, the selected one is the first found when counting upward, with wrap-around, from the slot after the last issued slot. The search starts at slot 0 after reset.
- R6: When no slot is eligible, iss_valid is 0 and the round-robin position is left unchanged.
- R7: The second instruction also issues (iss_lane1=1) when lane1_dep for the slot is 0, its class differs from the first instruction's class, and that class is not busy. Class fields are packed per slot s at bits [s*CLS_W +: CLS_W], and busy bit c belongs to class c.
- R8: In every other case an issued warp sends only its first instruction (iss_lane0=1, iss_lane1=0), and iss_lane1 is never 1 without iss_lane0.
- R9: A selection made from the inputs of cycle N appears on the outputs in cycle N+1. Consecutive cycles may issue different warps with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| adm_en | input | 1 | Admit a warp this cycle |
| adm_slot | input | SLOT_W | Slot to fill |
| adm_wid | input | WID_W | Warp ID to store |
| ret_en | input | 1 | Retire a slot this cycle |
| ret_slot | input | SLOT_W | Slot to clear |
| warp_ready | input | NUM_SLOTS | Per-slot operands-ready bit |
| lane0_cls | input | NUM_SLOTS*CLS_W | Per-slot unit class of the first instruction |
| lane1_cls | input | NUM_SLOTS*CLS_W | Per-slot unit class of the second instruction |
| lane1_dep | input | NUM_SLOTS | 1 when the second instruction depends on the first |
| unit_busy | input | NUM_CLASSES | Per-class busy bit |
| iss_valid | output | 1 | An issue happened |
| iss_slot | output | SLOT_W | Slot of the issued warp |
| iss_wid | output | WID_W | Warp ID of the issued warp |
| iss_lane0 | output | 1 | First instruction issued |
| iss_lane1 | output | 1 | Second instruction issued |

## Verification
Every issue output is due exactly one clock edge after the inputs that produce it. The bench therefore drives each vector at a falling edge and compares the outputs at the next falling edge, when the single rising edge between them has registered the selection. Admit and retire act on the slot table at that same rising edge, so their effect is first checked on the vector that follows. The latency check samples just after the inputs change, before any edge, and confirms that the old result is still present.

// File: rtl/wsched_pkg.sv
package wsched_pkg;
   typedef enum logic [1:0] {
      PAIR_NONE = 2'd0,
      PAIR_ONE  = 2'd1,
      PAIR_TWO  = 2'd2
   } pair_e;
endpackage

// File: rtl/wsched_slot_table.sv
module wsched_slot_table #(
   parameter int NUM_SLOTS = 8,
   parameter int WID_W     = 6,
   localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       adm_en,
   input  logic [SLOT_W-1:0]          adm_slot,
   input  logic [WID_W-1:0]           adm_wid,
   input  logic                       ret_en,
   input  logic [SLOT_W-1:0]          ret_slot,
   output logic [NUM_SLOTS-1:0]       resident,
   output logic [NUM_SLOTS*WID_W-1:0] wid_flat
);
   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      // retire has priority; admit only lands in a free slot (R2, R3)
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            resident[s]               <= 1'b0;
            wid_flat[s*WID_W +: WID_W] <= '0;
         end else if (ret_en && ret_slot == SLOT_W'(s)) begin
            resident[s] <= 1'b0;
         end else if (adm_en && adm_slot == SLOT_W'(s) && !resident[s]) begin
            resident[s]               <= 1'b1;
            wid_flat[s*WID_W +: WID_W] <= adm_wid;
         end
      end
   end
endmodule

// File: rtl/wsched_pair_check.sv
module wsched_pair_check
   import wsched_pkg::*;
#(
   parameter int NUM_SLOTS   = 8,
   parameter int NUM_CLASSES = 4,
   localparam int CLS_W      = $clog2(NUM_CLASSES)
) (
   input  logic [NUM_SLOTS-1:0]       resident,
   input  logic [NUM_SLOTS-1:0]       ready,
   input  logic [NUM_SLOTS*CLS_W-1:0] cls0,
   input  logic [NUM_SLOTS*CLS_W-1:0] cls1,
   input  logic [NUM_SLOTS-1:0]       dep,
   input  logic [NUM_CLASSES-1:0]     busy,
   output pair_e                      kind [NUM_SLOTS]
);
   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_lane
      logic [CLS_W-1:0] c0, c1;
      logic             go0, go1;
      assign c0  = cls0[s*CLS_W +: CLS_W];
      assign c1  = cls1[s*CLS_W +: CLS_W];
      assign go0 = resident[s] & ready[s] & ~busy[c0];
      assign go1 = go0 & ~dep[s] & (c1 != c0) & ~busy[c1];
      always_comb begin
         if (go1)      kind[s] = PAIR_TWO;
         else if (go0) kind[s] = PAIR_ONE;
         else          kind[s] = PAIR_NONE;
      end
   end
endmodule

// File: rtl/wsched_rr_pick.sv
module wsched_rr_pick #(
   parameter int N  = 8,
   localparam int IW = $clog2(N)
) (
   input  logic [N-1:0]  req,
   input  logic [IW-1:0] last,
   output logic          found,
   output logic [IW-1:0] idx
);
   always_comb begin
      found = 1'b0;
      idx   = last;
      for (int k = 1; k <= N; k++) begin
         if (!found && req[(int'(last) + k) % N]) begin
            found = 1'b1;
            idx   = IW'((int'(last) + k) % N);
         end
      end
   end
endmodule

// File: rtl/dual_issue_warp_sched.sv
module dual_issue_warp_sched
   import wsched_pkg::*;
#(
   parameter int NUM_SLOTS   = 8,
   parameter int WID_W       = 6,
   parameter int NUM_CLASSES = 4,
   localparam int SLOT_W     = $clog2(NUM_SLOTS),
   localparam int CLS_W      = $clog2(NUM_CLASSES)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       adm_en,
   input  logic [SLOT_W-1:0]          adm_slot,
   input  logic [WID_W-1:0]           adm_wid,
   input  logic                       ret_en,
   input  logic [SLOT_W-1:0]          ret_slot,
   input  logic [NUM_SLOTS-1:0]       warp_ready,
   input  logic [NUM_SLOTS*CLS_W-1:0] lane0_cls,
   input  logic [NUM_SLOTS*CLS_W-1:0] lane1_cls,
   input  logic [NUM_SLOTS-1:0]       lane1_dep,
   input  logic [NUM_CLASSES-1:0]     unit_busy,
   output logic                       iss_valid,
   output logic [SLOT_W-1:0]          iss_slot,
   output logic [WID_W-1:0]           iss_wid,
   output logic                       iss_lane0,
   output logic                       iss_lane1
);
   if (NUM_SLOTS < 2 || (1 << SLOT_W) != NUM_SLOTS) begin : g_bad_slots
      $error("NUM_SLOTS must be a power of two, at least 2");
   end
   if (NUM_CLASSES < 2 || (1 << CLS_W) != NUM_CLASSES) begin : g_bad_cls
      $error("NUM_CLASSES must be a power of two, at least 2");
   end
   if (WID_W < 1) begin : g_bad_wid
      $error("WID_W must be at least 1");
   end

   logic [NUM_SLOTS-1:0]       resident;
   logic [NUM_SLOTS*WID_W-1:0] wid_flat;
   pair_e                      kind [NUM_SLOTS];
   logic [NUM_SLOTS-1:0]       elig;
   logic                       found;
   logic [SLOT_W-1:0]          pick, last_q;

   wsched_slot_table #(.NUM_SLOTS(NUM_SLOTS), .WID_W(WID_W)) u_table (
      .clk(clk), .rst_n(rst_n),
      .adm_en(adm_en), .adm_slot(adm_slot), .adm_wid(adm_wid),
      .ret_en(ret_en), .ret_slot(ret_slot),
      .resident(resident), .wid_flat(wid_flat)
   );

   wsched_pair_check #(.NUM_SLOTS(NUM_SLOTS), .NUM_CLASSES(NUM_CLASSES)) u_pair (
      .resident(resident), .ready(warp_ready),
      .cls0(lane0_cls), .cls1(lane1_cls), .dep(lane1_dep),
      .busy(unit_busy), .kind(kind)
   );

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_elig
      assign elig[s] = (kind[s] != PAIR_NONE);
   end

   wsched_rr_pick #(.N(NUM_SLOTS)) u_pick (
      .req(elig), .last(last_q), .found(found), .idx(pick)
   );

   // pointer starts at the top slot so the first search begins at slot 0 (R5)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_q    <= SLOT_W'(NUM_SLOTS - 1);
         iss_valid <= 1'b0;
         iss_slot  <= '0;
         iss_wid   <= '0;
         iss_lane0 <= 1'b0;
         iss_lane1 <= 1'b0;
      end else begin
         if (found) last_q <= pick;    // held when nothing issues (R6)
         iss_valid <= found;
         iss_slot  <= found ? pick : '0;
         iss_wid   <= found ? wid_flat[pick*WID_W +: WID_W] : '0;
         iss_lane0 <= found;
         iss_lane1 <= found && (kind[pick] == PAIR_TWO);
      end
   end
endmodule

// File: rtl/wsched_chk.sv
module wsched_chk #(
   parameter int NUM_SLOTS   = 8,
   parameter int WID_W       = 6,
   parameter int NUM_CLASSES = 4,
   localparam int SLOT_W     = $clog2(NUM_SLOTS),
   localparam int CLS_W      = $clog2(NUM_CLASSES)
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic [NUM_SLOTS-1:0]       resident,
   input logic [NUM_SLOTS-1:0]       warp_ready,
   input logic [NUM_SLOTS*CLS_W-1:0] lane0_cls,
   input logic [NUM_SLOTS*CLS_W-1:0] lane1_cls,
   input logic [NUM_SLOTS-1:0]       lane1_dep,
   input logic [NUM_CLASSES-1:0]     unit_busy,
   input logic                       iss_valid,
   input logic [SLOT_W-1:0]          iss_slot,
   input logic [WID_W-1:0]           iss_wid,
   input logic                       iss_lane0,
   input logic                       iss_lane1
);
   logic                       seen;
   logic [NUM_SLOTS-1:0]       p_res, p_rdy, p_dep;
   logic [NUM_SLOTS*CLS_W-1:0] p_c0, p_c1;
   logic [NUM_CLASSES-1:0]     p_busy;
   logic                       p_any;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen <= 1'b0; p_res <= '0; p_rdy <= '0; p_dep <= '0;
         p_c0 <= '0; p_c1 <= '0; p_busy <= '0;
      end else begin
         seen <= 1'b1; p_res <= resident; p_rdy <= warp_ready; p_dep <= lane1_dep;
         p_c0 <= lane0_cls; p_c1 <= lane1_cls; p_busy <= unit_busy;
      end
   end

   always_comb begin
      p_any = 1'b0;
      for (int s = 0; s < NUM_SLOTS; s++)
         p_any = p_any | (p_res[s] & p_rdy[s] & ~p_busy[p_c0[s*CLS_W +: CLS_W]]);
   end

   p_lane1_needs_lane0_r8: assert property (@(posedge clk) disable iff (!rst_n)
      iss_lane1 |-> (iss_lane0 && iss_valid));

   p_issue_eligible_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && iss_valid) |-> (p_res[iss_slot] && p_rdy[iss_slot]
                               && !p_busy[p_c0[iss_slot*CLS_W +: CLS_W]]));

   p_dual_rules_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && iss_lane1) |-> (!p_dep[iss_slot]
                               && p_c0[iss_slot*CLS_W +: CLS_W] != p_c1[iss_slot*CLS_W +: CLS_W]
                               && !p_busy[p_c1[iss_slot*CLS_W +: CLS_W]]));

   p_idle_when_none_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && !p_any) |-> !iss_valid);

   p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !iss_valid |-> (iss_wid == '0 && iss_slot == '0 && !iss_lane0));
endmodule

bind dual_issue_warp_sched wsched_chk #(
   .NUM_SLOTS(NUM_SLOTS), .WID_W(WID_W), .NUM_CLASSES(NUM_CLASSES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .resident(resident), .warp_ready(warp_ready),
   .lane0_cls(lane0_cls), .lane1_cls(lane1_cls), .lane1_dep(lane1_dep),
   .unit_busy(unit_busy), .iss_valid(iss_valid), .iss_slot(iss_slot),
   .iss_wid(iss_wid), .iss_lane0(iss_lane0), .iss_lane1(iss_lane1)
);

// File: tb/test_dual_issue_warp_sched.sv
module test_dual_issue_warp_sched;
   localparam int NS = 8, WW = 6, NC = 4, SW = 3, CW = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic adm_en = 1'b0, ret_en = 1'b0;
   logic [SW-1:0] adm_slot = '0, ret_slot = '0;
   logic [WW-1:0] adm_wid = '0;
   logic [NS-1:0] warp_ready = '0, lane1_dep = '0;
   logic [NS*CW-1:0] lane0_cls = '0, lane1_cls = 16'h5515;  // slot 3: both lanes class 0
   logic [NC-1:0] unit_busy = '0;
   logic iss_valid, iss_lane0, iss_lane1;
   logic [SW-1:0] iss_slot;
   logic [WW-1:0] iss_wid;
   int errors = 0, checks = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;  // 50 MHz

   dual_issue_warp_sched i_dual_issue_warp_sched (
      .clk(clk), .rst_n(rst_n), .adm_en(adm_en), .adm_slot(adm_slot), .adm_wid(adm_wid),
      .ret_en(ret_en), .ret_slot(ret_slot), .warp_ready(warp_ready),
      .lane0_cls(lane0_cls), .lane1_cls(lane1_cls), .lane1_dep(lane1_dep),
      .unit_busy(unit_busy), .iss_valid(iss_valid), .iss_slot(iss_slot),
      .iss_wid(iss_wid), .iss_lane0(iss_lane0), .iss_lane1(iss_lane1)
   );

   // {ready, dep, busy, exp_valid, exp_slot, exp_wid, exp_lane0, exp_lane1}
   localparam int NV = 10;
   localparam logic [31:0] VEC [NV] = '{
      {8'hFF, 8'h00, 4'h0, 1'b1, 3'd0, 6'd10, 1'b1, 1'b1},
      {8'hFF, 8'h00, 4'h0, 1'b1, 3'd1, 6'd11, 1'b1, 1'b1},
      {8'hFF, 8'h04, 4'h0, 1'b1, 3'd2, 6'd12, 1'b1, 1'b0},
      {8'hFF, 8'h00, 4'h0, 1'b1, 3'd3, 6'd13, 1'b1, 1'b0},
      {8'h01, 8'h00, 4'h2, 1'b1, 3'd0, 6'd10, 1'b1, 1'b0},
      {8'hFF, 8'h00, 4'h1, 1'b0, 3'd0, 6'd0,  1'b0, 1'b0},
      {8'hC0, 8'h00, 4'h0, 1'b0, 3'd0, 6'd0,  1'b0, 1'b0},
      {8'h22, 8'h00, 4'h0, 1'b1, 3'd1, 6'd11, 1'b1, 1'b1},
      {8'h22, 8'h00, 4'h0, 1'b1, 3'd5, 6'd15, 1'b1, 1'b1},
      {8'hFF, 8'h00, 4'h0, 1'b1, 3'd0, 6'd10, 1'b1, 1'b1}
   };

   function automatic string vec_req(int i);
      case (i)
         0: return "R5 first search from slot 0";
         1: return "R9 switch warp next cycle";
         2: return "R8 dependent second";
         3: return "R7 same class blocks second";
         4: return "R8 second unit busy";
         5: return "R4 first unit busy";
         6: return "R4 non-resident ready";
         7: return "R6 pointer held";
         8: return "R5 skip to next eligible";
         default: return "R5 wrap-around";
      endcase
   endfunction

   task automatic chk(string req, logic v, logic [SW-1:0] s, logic [WW-1:0] w, logic l0, logic l1);
      checks++;
      if ({iss_valid, iss_slot, iss_wid, iss_lane0, iss_lane1} !== {v, s, w, l0, l1}) begin
         errors++;
         $display("FAIL %s: got v=%0b slot=%0d wid=%0d l0=%0b l1=%0b exp v=%0b slot=%0d wid=%0d l0=%0b l1=%0b",
                  req, iss_valid, iss_slot, iss_wid, iss_lane0, iss_lane1, v, s, w, l0, l1);
      end
   endtask

   // called at a falling edge; the slot table updates at the following rising edge
   task automatic admit(int slot, int wid);
      adm_en = 1'b1; adm_slot = SW'(slot); adm_wid = WW'(wid);
      @(negedge clk);
      adm_en = 1'b0;
   endtask

   task automatic apply(logic [7:0] rdy, logic [7:0] dp, logic [3:0] bz);
      warp_ready = rdy; lane1_dep = dp; unit_busy = bz;
      @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: got hang exp completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 in reset", 0, 0, 0, 0, 0);
      rst_n = 1'b1;
      apply(8'hFF, 8'h00, 4'h0);
      chk("R1 nothing resident after reset", 0, 0, 0, 0, 0);
      warp_ready = '0;
      for (int s = 0; s < 6; s++) admit(s, 10 + s);
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         apply(VEC[i][31:24], VEC[i][23:16], VEC[i][15:12]);
         chk(vec_req(i), VEC[i][11], VEC[i][10:8], VEC[i][7:2], VEC[i][1], VEC[i][0]);
      end

      // R2: admit to an occupied slot keeps its warp ID
      warp_ready = '0;
      admit(1, 50);
      apply(8'h02, 8'h00, 4'h0);
      chk("R2 occupied admit ignored", 1, 1, 11, 1, 1);

      // R3: retire and admit on slot 0 together; retire wins
      warp_ready = '0;
      ret_en = 1'b1; ret_slot = 3'd0; adm_en = 1'b1; adm_slot = 3'd0; adm_wid = 6'd40;
      @(negedge clk);
      ret_en = 1'b0; adm_en = 1'b0;
      apply(8'h01, 8'h00, 4'h0);
      chk("R3 retired slot not issued", 0, 0, 0, 0, 0);

      // R2: admit into the now free slot
      warp_ready = '0;
      admit(0, 40);
      apply(8'h01, 8'h00, 4'h0);
      chk("R2 admit into free slot", 1, 0, 40, 1, 1);

      // R9: result is not visible before the next rising edge
      warp_ready = '0;
      #1;
      chk("R9 no change before edge", 1, 0, 40, 1, 1);
      @(negedge clk);
      chk("R9 change after one edge", 0, 0, 0, 0, 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule